// File: doc/BRIEF.md
# SIMD Saturating Rounding Variable Shifter

This block is a lane-parallel vector datapath. It takes a data vector and a count vector. Each data lane is shifted by a signed count held in the low byte of the matching count lane. A non-negative count shifts left. A negative count shifts right by its magnitude and rounds to nearest, with halves rounded upward. Each lane result is clamped to the signed or unsigned range of its element width. A sticky flag records that some lane saturated, and it stays set until software clears it explicitly.

The element size is 8, 16, 32 or 64 bits, chosen by a 2-bit size code. The operation covers either a 64-bit vector (the low half of the buses) or a full 128-bit vector. In 128-bit mode, an operation whose destination or source register index is odd is illegal. Such an operation produces no result and raises an undefined-operation strobe instead. Results are registered, so they appear one clock after the input strobe.

Top module: `simd_rshift_sat`

## Requirements
- R1: Element width is 8 << size_code bits, and lanes are packed from bit 0 upward. When wide_sel is 0, only bits [63:0] are processed: result bits [127:64] are 0, and upper-half lanes never affect the saturation flag.
- R2: A lane's shift count is bits [7:0] of the matching lane of opb, read as two's complement. The remaining bits of that lane have no effect.
- R3: For a count c >= 0, the lane value is shifted left by c at full precision before any range check. A zero element gives 0 and does not saturate. A nonzero element shifted by at least the element width saturates.
- R4: For a count c < 0, with s = -c, the lane result is (x + 2^(s-1)) >> s, computed arithmetically at full precision. For example, signed -1 with c = -128 gives 0, and unsigned 8-bit 0x80 with c = -8 gives 1.
- R5: With is_unsigned = 1, lanes are read as unsigned and clamped to [0, 2^w-1]. With is_unsigned = 0, lanes are read as two's complement and clamped to [-2^(w-1), 2^(w-1)-1].
- R6: sat_sticky is set by any accepted operation in which some processed lane saturates. It is cleared only by sat_clear. If a clear and a saturating operation arrive in the same cycle, the flag ends up set.
- R7: out_valid is asserted exactly one clock after an accepted in_valid. out_result and sat_sticky update on that same edge.
- R8: When wide_sel = 1 and any of dst_odd, srca_odd or srcb_odd is 1, the operation is rejected. out_undef pulses one clock later, out_valid stays 0, out_result holds its previous value, and the operation cannot set sat_sticky.
- R9: After reset, out_valid, out_undef, sat_sticky and out_result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| wide_sel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| size_code | input | 2 | Element width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| is_unsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| dst_odd | input | 1 | Low bit of the destination register index |
| srca_odd | input | 1 | Low bit of the data source register index |
| srcb_odd | input | 1 | Low bit of the count source register index |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| opa | input | 128 | Data vector |
| opb | input | 128 | Count vector; low byte of each lane is the count |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Result vector |
| out_undef | output | 1 | Illegal-operation strobe |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Each of the eight element types is run in both vector widths with random data. Per-lane counts are drawn from the boundary set -128, -1, 0, 1, 127 and from a small range around plus and minus the element width. This separates the left-shift saturation threshold from the rounding behaviour at small right shifts and from the collapse-to-zero behaviour at large right shifts. Directed operations isolate four further cases: a round-up at exactly half, a zero element under the maximum left count, junk in the upper count bits, and saturating data placed only in the ignored upper half. Illegal odd-index operations and interleaved clears show that the sticky flag and the held result are disturbed only by accepted operations.

// File: rtl/simd_rshift_sat.sv
module simd_rshift_sat (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         wide_sel,
  input  logic [1:0]   size_code,
  input  logic         is_unsigned,
  input  logic         dst_odd,
  input  logic         srca_odd,
  input  logic         srcb_odd,
  input  logic         sat_clear,
  input  logic [127:0] opa,
  input  logic [127:0] opb,
  output logic         out_valid,
  output logic [127:0] out_result,
  output logic         out_undef,
  output logic         sat_sticky
);

  // returns {saturated, clamped value}; low ew bits are the lane result
  function automatic logic [64:0] lane_op(input logic [63:0] elt, input logic [7:0] cnt,
                                          input int ew, input logic uns);
    logic signed [129:0] x, y, hi, lo;
    int s;
    x = $signed({66'd0, elt});
    if (!uns && elt[ew-1]) x = x - (130'sd1 <<< ew);
    if (!cnt[7]) begin
      s = (cnt > 8'd64) ? 64 : int'(cnt);
      y = x <<< s;
    end else begin
      s = 256 - int'(cnt);
      if (s > 65) s = 65;
      y = (x + (130'sd1 <<< (s - 1))) >>> s;
    end
    hi = uns ? (130'sd1 <<< ew) - 130'sd1 : (130'sd1 <<< (ew - 1)) - 130'sd1;
    lo = uns ? 130'sd0 : -(130'sd1 <<< (ew - 1));
    if (y > hi) return {1'b1, hi[63:0]};
    if (y < lo) return {1'b1, lo[63:0]};
    return {1'b0, y[63:0]};
  endfunction

  logic [3:0][127:0] res_by_sz;
  logic [3:0][15:0]  sat_by_sz;

  for (genvar z = 0; z < 4; z++) begin : g_sz
    localparam int EW = 8 << z;
    localparam int NL = 128 / EW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [64:0] o;
      logic        live;
      assign live = wide_sel || (l < NL / 2);
      assign o = lane_op(64'(opa[l*EW +: EW]), opb[l*EW +: 8], EW, is_unsigned);
      assign res_by_sz[z][l*EW +: EW] = live ? o[EW-1:0] : '0;
      assign sat_by_sz[z][l] = live & o[64];
    end
    if (NL < 16) begin : g_pad
      assign sat_by_sz[z][15:NL] = '0;
    end
  end

  logic illegal, accept, any_sat;
  assign illegal = wide_sel & (dst_odd | srca_odd | srcb_odd);
  assign accept  = in_valid & ~illegal;
  assign any_sat = |sat_by_sz[size_code];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_result <= '0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= accept;
      out_undef  <= in_valid & illegal;
      if (accept) out_result <= res_by_sz[size_code];
      sat_sticky <= (sat_sticky & ~sat_clear) | (accept & any_sat);
    end
  end

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal |=> out_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_undef);
  assert_undef_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_undef));
  assert_undef_holds_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && illegal |=> $stable(out_result) && out_undef);
  assert_sticky_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clear |=> sat_sticky);
  assert_sticky_rise_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_sticky && !in_valid |=> !sat_sticky);
  assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide_sel |=> out_result[127:64] == 64'd0);

endmodule

// File: tb/test_simd_rshift_sat.sv
module test_simd_rshift_sat;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, wide_sel = 0, is_unsigned = 0, dst_odd = 0, srca_odd = 0, srcb_odd = 0, sat_clear = 0;
  logic [1:0] size_code = 0;
  logic [127:0] opa = '0, opb = '0;
  logic out_valid, out_undef, sat_sticky;
  logic [127:0] out_result;

  simd_rshift_sat i_simd_rshift_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel), .size_code(size_code),
    .is_unsigned(is_unsigned), .dst_odd(dst_odd), .srca_odd(srca_odd), .srcb_odd(srcb_odd),
    .sat_clear(sat_clear), .opa(opa), .opb(opb), .out_valid(out_valid), .out_result(out_result),
    .out_undef(out_undef), .sat_sticky(sat_sticky));

  always #4 clk = ~clk;

  typedef struct { logic [127:0] res; bit undef; bit sticky; int cyc; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0, cyc = 0;
  bit sticky_m = 0;
  logic [127:0] last_res = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_lane(int ew, bit uns, logic [63:0] a, logic [7:0] c, output bit sat);
    logic signed [199:0] v, r, mx, mn;
    int sh;
    v = $signed({136'd0, a});
    if (!uns && a[ew-1]) v = v - (200'sd1 <<< ew);
    sh = int'($signed(c));
    if (sh >= 0) r = v <<< sh;
    else r = (v + (200'sd1 <<< (-sh - 1))) >>> (-sh);
    mx = uns ? (200'sd1 <<< ew) - 1 : (200'sd1 <<< (ew - 1)) - 1;
    mn = uns ? 200'sd0 : -(200'sd1 <<< (ew - 1));
    sat = (r > mx) || (r < mn);
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return r[63:0];
  endfunction

  task automatic do_op(bit wide, logic [1:0] sz, bit uns, logic [127:0] a, logic [127:0] b,
                       bit dod, bit aod, bit bod, bit clr, string tag);
    exp_t e;
    int ew, nl;
    bit any, s, legal;
    logic [63:0] av, rv;
    logic [127:0] r;
    ew = 8 << sz; nl = 128 / ew; any = 0; r = '0;
    for (int l = 0; l < nl; l++) begin
      if (!wide && l >= nl / 2) continue;
      av = '0;
      for (int k = 0; k < ew; k++) av[k] = a[l*ew + k];
      rv = ref_lane(ew, uns, av, b[l*ew +: 8], s);
      any |= s;
      for (int k = 0; k < ew; k++) r[l*ew + k] = rv[k];
    end
    legal = !(wide && (dod || aod || bod));
    if (legal) begin last_res = r; sticky_m = (sticky_m & !clr) | any; end
    else sticky_m = sticky_m & !clr;
    e.res = last_res; e.undef = !legal; e.sticky = sticky_m; e.cyc = cyc; e.tag = tag;
    sb.push_back(e);
    in_valid = 1; wide_sel = wide; size_code = sz; is_unsigned = uns; opa = a; opb = b;
    dst_odd = dod; srca_odd = aod; srcb_odd = bod; sat_clear = clr;
    @(negedge clk);
    in_valid = 0; sat_clear = 0; dst_odd = 0; srca_odd = 0; srcb_odd = 0;
  endtask

  task automatic clear_flag();
    sat_clear = 1; sticky_m = 0;
    @(negedge clk);
    sat_clear = 0;
    chk(sat_sticky == 0, "R6 clear", 128'(sat_sticky), 128'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || out_undef)) begin
      if (sb.size() == 0) chk(0, "R7 unexpected output", 128'(out_valid), 128'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.cyc + 1, {e.tag, " R7 latency"}, 128'(cyc), 128'(e.cyc + 1));
        chk(out_undef == e.undef, {e.tag, " R8 undef"}, 128'(out_undef), 128'(e.undef));
        chk(out_result == e.res, {e.tag, " result"}, out_result, e.res);
        chk(sat_sticky == e.sticky, {e.tag, " R6 sticky"}, 128'(sat_sticky), 128'(e.sticky));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_undef == 0, "R9 reset strobes", 128'({out_valid, out_undef}), 128'd0);
    chk(sat_sticky == 0, "R9 reset sticky", 128'(sat_sticky), 128'd0);
    chk(out_result == 0, "R9 reset result", out_result, 128'd0);
    rst_n = 1;
    @(negedge clk);

    do_op(0, 0, 0, 128'hFF, 128'h80, 0, 0, 0, 0, "R4 s8 -1 by -128");
    do_op(0, 0, 1, 128'h80, 128'hF8, 0, 0, 0, 0, "R4 u8 half round up");
    clear_flag();
    do_op(1, 0, 0, 128'h0, {16{8'h7F}}, 0, 0, 0, 0, "R3 zero by 127");
    do_op(0, 1, 0, 128'h0001, 128'h000F, 0, 0, 0, 0, "R3 R5 s16 overflow");
    do_op(0, 1, 1, 128'h0100, 128'hAB02, 0, 0, 0, 0, "R2 upper count bits");
    clear_flag();
    do_op(0, 0, 0, {{8{8'h7F}}, 64'h0}, {{8{8'h7F}}, 64'h0}, 0, 0, 0, 0, "R1 narrow upper ignored");
    do_op(0, 2, 1, 128'hFFFF_FFFF, 128'h01, 0, 0, 0, 0, "R5 u32 clamp");
    do_op(1, 0, 0, 128'h1, 128'h0, 1, 0, 0, 0, "R8 odd dst");
    do_op(1, 3, 1, 128'h1, 128'h7F, 0, 0, 1, 0, "R8 odd count src");
    do_op(0, 0, 0, 128'h01, 128'h00, 0, 0, 0, 0, "R6 no-sat keeps flag");
    do_op(0, 0, 0, 128'h7F, 128'h01, 0, 0, 0, 1, "R6 clear with sat");

    for (int t = 0; t < 8; t++) begin
      for (int w = 0; w < 2; w++) begin
        for (int it = 0; it < 12; it++) begin
          int ew;
          ew = 8 << (t % 4);
          a = {$urandom, $urandom, $urandom, $urandom};
          b = {$urandom, $urandom, $urandom, $urandom};
          if (it % 3 == 0) a = a >> ($urandom % 128);
          for (int l = 0; l < 128 / ew; l++) begin
            int k, sm;
            k = int'($urandom % 8);
            sm = int'($urandom % (2 * ew + 5)) - ew - 2;
            case (k)
              0: b[l*ew +: 8] = 8'h80;
              1: b[l*ew +: 8] = 8'hFF;
              2: b[l*ew +: 8] = 8'h00;
              3: b[l*ew +: 8] = 8'h01;
              4: b[l*ew +: 8] = 8'h7F;
              default: b[l*ew +: 8] = sm[7:0];
            endcase
          end
          if (it == 5) clear_flag();
          do_op(w[0], 2'(t % 4), t >= 4, a, b, 0, 0, 0, 0, "R1 R3 R4 R5 random");
        end
      end
    end

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 all results seen", 128'(sb.size()), 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule